// File: doc/BRIEF.md
# Drive command strobe and seek sequencer

This block sits between a floppy controller's register file and the drive cable. Outside a seek it copies the software select value onto the three drive phase lines, the head-select line and the command strobe, so software can issue any drive command (set the phase lines, pulse the strobe) or pick a status condition to sense. Drive status comes back on one shared active-low sense line. The block resynchronises that line and presents it as a condition-true flag.

For multi-track moves, software first issues a step-direction command through the select path. It then loads a track count and sets the start-seek control bit. The sequencer takes over the phase lines, forces the step command code and emits strobe pulses timed from a 1 MHz tick. It counts the remaining tracks down by one at the end of each pulse and raises seek-done when the count reaches zero. Clearing the start-seek bit abandons the seek at once and keeps the remaining count.

Top module: `fdd_cmd_seek`

## Requirements
- R1: After reset phase_o is 3 (the relax code), head_o, strobe_o and seek_done_o are 0, and steps_left_o is 0.
- R2: When no seek is stepping, phase_o equals sel_reg_i[2:0], strobe_o equals sel_reg_i[3] and head_o equals head_sel_i, one clock after the inputs.
- R3: cond_o is the inverse of sense_ni two clocks later, because a low sense level means the queried condition is true.
- R4: A pulse on nseek_we_i loads nseek_wdata_i into the step count (shown on steps_left_o the next clock) only when the sequencer is idle. A load while stepping or while seek-done is held is ignored.
- R5: While stepping, phase_o is 3'b001 and head_o is 0 (step command code 1). Each strobe pulse starts LEAD_TICKS ticks after step start and stays high for exactly PULSE_TICKS ticks.
- R6: steps_left_o drops by one on the clock where each step pulse ends, and the number of pulses equals the loaded count.
- R7: Rising edges of consecutive step pulses are exactly STEP_TICKS ticks apart.
- R8: seek_done_o rises on the clock where the last pulse ends, with steps_left_o at 0. It stays high while seek_go_i is held and clears one clock after seek_go_i is low.
- R9: Raising seek_go_i with a zero count sets seek_done_o on the next clock and produces no step pulse.
- R10: Dropping seek_go_i mid-seek returns strobe_o and phase_o to the select-path values on the next clock, without raising seek_done_o. A pulse that is cut short does not count. Raising seek_go_i again steps the remaining count.
- R11: While seek_done_o is held, no further step pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse at 1 MHz |
| sel_reg_i | input | 4 | Select value: [2:0] phase code, [3] strobe |
| head_sel_i | input | 1 | Fourth command/query address bit |
| seek_go_i | input | 1 | Start-seek control bit (level) |
| nseek_we_i | input | 1 | Step-count load strobe |
| nseek_wdata_i | input | CNT_W | Step count to load |
| sense_ni | input | 1 | Drive sense line, active low |
| phase_o | output | 3 | Drive phase lines |
| head_o | output | 1 | Drive head-select line |
| strobe_o | output | 1 | Drive command strobe |
| steps_left_o | output | CNT_W | Remaining step count |
| seek_done_o | output | 1 | Seek complete |
| cond_o | output | 1 | Sensed condition is true |

## Verification
Seeks are run with random track counts, with tick rates of one, two and three clocks, and with random select values held underneath. This separates timing counted in ticks from timing counted in clocks, and shows that the forced step code really overrides software. A zero count, aborts between pulses and in mid-pulse, each followed by a resume, and a count write issued during stepping separate pulse counting from pulse timing. They also show that a partial pulse is not counted. Random select and sense patterns outside a seek check that the pass-through and the inverted two-stage sense path keep their latency.

// File: rtl/fdd_cmd_seek_pkg.sv
package fdd_cmd_seek_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_STEP, SQ_DONE} seq_state_e;
  localparam logic [3:0] CMD_STEP  = 4'd1;
  localparam logic [3:0] QRY_RELAX = 4'd3;
endpackage

// File: rtl/fdd_sense_sync.sv
module fdd_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sense_ni,
  output logic cond_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], sense_ni};
  end

  assign cond_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/fdd_seek_seq.sv
module fdd_seek_seq
  import fdd_cmd_seek_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int LEAD_TICKS  = 1,
  parameter int PULSE_TICKS = 2,
  parameter int STEP_TICKS  = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             stepping_o,
  output logic             strobe_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remain_o
);
  localparam int TW = $clog2(STEP_TICKS);
  localparam logic [TW-1:0] T_ON   = TW'(LEAD_TICKS);
  localparam logic [TW-1:0] T_OFF  = TW'(LEAD_TICKS + PULSE_TICKS);
  localparam logic [TW-1:0] T_LAST = TW'(LEAD_TICKS + PULSE_TICKS - 1);
  localparam logic [TW-1:0] T_END  = TW'(STEP_TICKS - 1);

  seq_state_e       state_q;
  logic [TW-1:0]    tcnt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      tcnt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (load_i) cnt_q <= load_val_i;
          if (go_i) begin
            tcnt_q  <= '0;
            state_q <= (cnt_q == '0) ? SQ_DONE : SQ_STEP;
          end
        end
        SQ_STEP: begin
          if (!go_i) begin
            state_q <= SQ_IDLE;
          end else if (tick_i) begin
            // pulse ends on this tick: count the track
            if (tcnt_q == T_LAST) begin
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) state_q <= SQ_DONE;
            end
            tcnt_q <= (tcnt_q == T_END) ? '0 : tcnt_q + 1'b1;
          end
        end
        SQ_DONE: if (!go_i) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign stepping_o = (state_q == SQ_STEP);
  assign strobe_o   = stepping_o && (tcnt_q >= T_ON) && (tcnt_q < T_OFF);
  assign done_o     = (state_q == SQ_DONE);
  assign remain_o   = cnt_q;
endmodule

// File: rtl/fdd_cmd_mux.sv
module fdd_cmd_mux
  import fdd_cmd_seek_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sel_reg_i,
  input  logic       head_sel_i,
  input  logic       stepping_i,
  input  logic       step_strobe_i,
  output logic [2:0] phase_o,
  output logic       head_o,
  output logic       strobe_o
);
  logic [3:0] sel_q;
  logic       head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= QRY_RELAX;
      head_q <= 1'b0;
    end else begin
      sel_q  <= sel_reg_i;
      head_q <= head_sel_i;
    end
  end

  // sequencer owns the cable while stepping
  assign phase_o  = stepping_i ? CMD_STEP[2:0] : sel_q[2:0];
  assign head_o   = stepping_i ? CMD_STEP[3]   : head_q;
  assign strobe_o = stepping_i ? step_strobe_i : sel_q[3];
endmodule

// File: rtl/fdd_cmd_seek.sv
module fdd_cmd_seek #(
  parameter int CNT_W       = 8,
  parameter int LEAD_TICKS  = 1,
  parameter int PULSE_TICKS = 2,
  parameter int STEP_TICKS  = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [3:0]       sel_reg_i,
  input  logic             head_sel_i,
  input  logic             seek_go_i,
  input  logic             nseek_we_i,
  input  logic [CNT_W-1:0] nseek_wdata_i,
  input  logic             sense_ni,
  output logic [2:0]       phase_o,
  output logic             head_o,
  output logic             strobe_o,
  output logic [CNT_W-1:0] steps_left_o,
  output logic             seek_done_o,
  output logic             cond_o
);
  logic stepping, step_strobe;

  fdd_seek_seq #(
    .CNT_W(CNT_W), .LEAD_TICKS(LEAD_TICKS),
    .PULSE_TICKS(PULSE_TICKS), .STEP_TICKS(STEP_TICKS)
  ) seq_i (
    .clk_i, .rst_ni, .tick_i,
    .go_i(seek_go_i), .load_i(nseek_we_i), .load_val_i(nseek_wdata_i),
    .stepping_o(stepping), .strobe_o(step_strobe),
    .done_o(seek_done_o), .remain_o(steps_left_o)
  );

  fdd_cmd_mux mux_i (
    .clk_i, .rst_ni, .sel_reg_i, .head_sel_i,
    .stepping_i(stepping), .step_strobe_i(step_strobe),
    .phase_o, .head_o, .strobe_o
  );

  fdd_sense_sync #(.STAGES(2)) sense_i (
    .clk_i, .rst_ni, .sense_ni, .cond_o
  );
endmodule

// File: rtl/fdd_cmd_seek_chk.sv
module fdd_cmd_seek_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seek_go_i,
  input logic [2:0]       phase_o,
  input logic             head_o,
  input logic             strobe_o,
  input logic [CNT_W-1:0] steps_left_o,
  input logic             seek_done_o
);
  assert_step_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_go_i && $past(seek_go_i) && !seek_done_o) |-> (phase_o == 3'd1 && !head_o));

  assert_pulse_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(strobe_o) && seek_go_i && $past(seek_go_i) && !$past(seek_done_o))
      |-> (steps_left_o == $past(steps_left_o) - 1'b1));

  assert_done_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_done_o |-> (steps_left_o == '0));

  assert_done_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seek_go_i |=> !seek_done_o);

  assert_zero_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(seek_go_i) && steps_left_o == '0) |=> seek_done_o);
endmodule

bind fdd_cmd_seek fdd_cmd_seek_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .seek_go_i(seek_go_i),
  .phase_o(phase_o), .head_o(head_o), .strobe_o(strobe_o),
  .steps_left_o(steps_left_o), .seek_done_o(seek_done_o)
);

// File: tb/fdd_cmd_seek_tb.sv
module fdd_cmd_seek_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LEAD  = 1;
  localparam int PULSE = 2;
  localparam int STEP  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [3:0] sel_reg_i = 4'd3;
  logic head_sel_i = 1'b0, seek_go_i = 1'b0, nseek_we_i = 1'b0, sense_ni = 1'b1;
  logic [CNT_W-1:0] nseek_wdata_i = '0;
  logic [2:0] phase_o;
  logic head_o, strobe_o, seek_done_o, cond_o;
  logic [CNT_W-1:0] steps_left_o;

  int n_chk = 0, n_fail = 0, tick_div = 1, tdiv_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdd_cmd_seek #(.CNT_W(CNT_W), .LEAD_TICKS(LEAD), .PULSE_TICKS(PULSE), .STEP_TICKS(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i, .sel_reg_i, .head_sel_i, .seek_go_i,
    .nseek_we_i, .nseek_wdata_i, .sense_ni, .phase_o, .head_o, .strobe_o,
    .steps_left_o, .seek_done_o, .cond_o);

  initial forever begin
    @(negedge clk);
    if (tdiv_cnt >= tick_div - 1) begin tick_i = 1'b1; tdiv_cnt = 0; end
    else begin tick_i = 1'b0; tdiv_cnt++; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cnt(input int v);
    nseek_we_i = 1'b1; nseek_wdata_i = CNT_W'(v);
    @(negedge clk);
    nseek_we_i = 1'b0;
  endtask

  // runs a seek expecting n pulses; optionally loads n first
  task automatic run_seek(input int n, input int div, input bit do_load);
    int pulses = 0, width = 0, last_rise = -1, cyc = 0;
    int bad_sp = 0, bad_w = 0, bad_ph = 0, bad_dec = 0, done_cyc = -1;
    bit prev_s = 1'b0, done_on_fall = 1'b0;
    tick_div = div;
    sel_reg_i = 4'($urandom_range(0, 7));
    head_sel_i = 1'b1;
    if (do_load) load_cnt(n);
    seek_go_i = 1'b1;
    while (cyc < 2000) begin
      @(negedge clk); cyc++;
      if (cyc == 2) begin nseek_we_i = 1'b1; nseek_wdata_i = 8'hAA; end
      if (cyc == 3) nseek_we_i = 1'b0;
      if (!seek_done_o && (phase_o != 3'd1 || head_o)) bad_ph++;
      if (strobe_o && !prev_s) begin
        if (last_rise >= 0 && cyc - last_rise != STEP*div) bad_sp++;
        last_rise = cyc; width = 0;
      end
      if (strobe_o) width++;
      if (!strobe_o && prev_s) begin
        pulses++;
        if (width != PULSE*div) bad_w++;
        if (int'(steps_left_o) != n - pulses) bad_dec++;
        if (pulses == n && seek_done_o) done_on_fall = 1'b1;
      end
      if (seek_done_o) begin done_cyc = cyc; break; end
      prev_s = strobe_o;
    end
    nseek_we_i = 1'b0;
    chk(bad_ph == 0, "R5 step code while stepping", bad_ph, 0);
    chk(bad_w == 0, "R5 pulse width", bad_w, 0);
    chk(pulses == n, "R6/R4 pulse count", pulses, n);
    chk(bad_dec == 0, "R6 decrement per pulse", bad_dec, 0);
    chk(bad_sp == 0, "R7 pulse spacing", bad_sp, 0);
    if (n == 0) chk(done_cyc == 1, "R9 zero count done", done_cyc, 1);
    else chk(done_on_fall, "R8 done at last fall", done_on_fall, 1);
    chk(steps_left_o == '0, "R8 count zero at done", steps_left_o, 0);
    // R11 hold: no pulses, done stays, load ignored
    nseek_we_i = 1'b1; nseek_wdata_i = 8'h55;
    @(negedge clk); nseek_we_i = 1'b0;
    begin
      int extra = 0;
      for (int i = 0; i < 3*STEP*div; i++) begin
        @(negedge clk);
        if (strobe_o != sel_reg_i[3] || !seek_done_o) extra++;
      end
      chk(extra == 0, "R11 no pulses while done held", extra, 0);
    end
    chk(steps_left_o == '0, "R4 load ignored while done", steps_left_o, 0);
    seek_go_i = 1'b0;
    @(negedge clk);
    chk(!seek_done_o, "R8 done clears", seek_done_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(phase_o == 3'd3, "R1 reset phase", phase_o, 3);
    chk(!head_o && !strobe_o && !seek_done_o, "R1 reset lines", {head_o, strobe_o, seek_done_o}, 0);
    chk(steps_left_o == '0, "R1 reset count", steps_left_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [3:0] s; logic h;
      s = 4'($urandom); h = 1'($urandom);
      sel_reg_i = s; head_sel_i = h;
      @(negedge clk);
      chk(phase_o == s[2:0] && strobe_o == s[3] && head_o == h, "R2 select pass-through",
          {head_o, strobe_o, phase_o}, {h, s[3], s[2:0]});
    end

    for (int i = 0; i < 20; i++) begin
      logic v;
      v = 1'($urandom);
      sense_ni = v;
      @(negedge clk);
      @(negedge clk);
      chk(cond_o == ~v, "R3 sense inverted", cond_o, ~v);
    end

    for (int i = 0; i < 4; i++) begin
      int v;
      v = $urandom_range(0, 255);
      load_cnt(v);
      chk(int'(steps_left_o) == v, "R4 idle load", steps_left_o, v);
    end

    run_seek(0, 1, 1'b1);
    run_seek(1, 1, 1'b1);
    for (int k = 0; k < 6; k++) run_seek($urandom_range(1, 9), $urandom_range(1, 3), 1'b1);

    // R10 abort between pulses
    tick_div = 1; sel_reg_i = 4'b0110; head_sel_i = 1'b0;
    load_cnt(5);
    seek_go_i = 1'b1;
    begin
      int falls = 0; bit ps = 1'b0;
      for (int c = 0; c < 500 && falls < 2; c++) begin
        @(negedge clk);
        if (!strobe_o && ps) falls++;
        ps = strobe_o;
      end
    end
    seek_go_i = 1'b0;
    @(negedge clk);
    chk(phase_o == 3'd6 && !strobe_o, "R10 abort releases lines", phase_o, 6);
    chk(!seek_done_o, "R10 abort no done", seek_done_o, 0);
    chk(steps_left_o == 8'd3, "R10 abort keeps count", steps_left_o, 3);
    run_seek(3, 1, 1'b0);

    // R10 abort mid-pulse
    sel_reg_i = 4'b0010; head_sel_i = 1'b0;
    load_cnt(4);
    seek_go_i = 1'b1;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (strobe_o) break;
    end
    seek_go_i = 1'b0;
    @(negedge clk);
    chk(!strobe_o && phase_o == 3'd2, "R10 mid-pulse abort", strobe_o, 0);
    chk(steps_left_o == 8'd4, "R10 cut pulse not counted", steps_left_o, 4);
    run_seek(4, 2, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule